// File: doc/BRIEF.md
# Split Floating-Point Status Register

This block stores the floating-point status and control word as three separately written registers instead of one. The volatile part carries the per-result bits: the rounded flag, the inexact flag and the five-bit result class. The sticky part carries the accumulated exception flags. The control part carries the rounding mode, the exception enables and the remaining mode bits. Splitting the word this way lets the three parts be tracked as independent operands. Most floating-point operations rewrite the volatile part, seldom change the sticky part and only read the control part.

An issuing floating-point operation reads all three parts through one combinational read port. A 32-bit concatenation is also provided for whole-word moves. The final pipeline stage returns one writeback record. The record holds three data/ok pairs, and each part is written only when its ok bit is set. Sticky results are OR-merged into the stored flags, so an arithmetic result can never clear a flag. A merge that would set no new flag is dropped. The block also has a whole-word write that overwrites everything, and a one-cycle pulse that tells the issuer the sticky flags really changed. Because it is in order, the issuer waits for these writes to finish before it fetches the next instruction.

Top module: `fpsr_split_regs`

## Requirements
- R1: After reset the volatile and sticky parts read as zero. The control part reads as zero, which means rounding mode 00 (round to nearest) and all exception enables off. `sticky_changed` is low.
- R2: The word read `rd_word` places the volatile part in bits [6:0], the sticky part in bits [18:7] and the control part in bits [31:19]. Each slice equals its separate read output.
- R3: On a clock edge with `wb_vol_ok` high and `mts_en` low, the volatile part takes `wb_vol`. Without `wb_vol_ok` it keeps its value whatever `wb_vol` holds.
- R4: On an edge with `wb_stk_ok` high and `mts_en` low, the sticky part becomes the stored flags OR `wb_stk`. A writeback never clears a set flag, and `wb_stk` is ignored while `wb_stk_ok` is low.
- R5: `sticky_changed` is high for exactly the cycle after an edge where an OR-merge set at least one previously clear flag. It stays low when every flag being merged was already set, and also when the merged value is zero.
- R6: The control part changes only on an edge with `wb_ctl_ok` high or `mts_en` high. Otherwise it keeps its value.
- R7: On an edge with `mts_en` high, all three parts take the matching slices of `mts_word` (layout as in R2), and this can clear sticky flags. It takes priority over every writeback pair in the same cycle and never raises `sticky_changed`.
- R8: Control bits outside `CTL_LIVE` have no storage and always read as the matching bits of `CTL_FIXED`, whatever is written. By default bits [12:8] read as 0 and bits [7:0] are stored.
- R9: The ok bits are independent: a pair whose ok bit is low leaves its part unchanged even when the other pairs write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_vol_ok | input | 1 | Volatile writeback valid |
| wb_vol | input | 7 | Volatile writeback data |
| wb_stk_ok | input | 1 | Sticky writeback valid |
| wb_stk | input | 12 | Newly detected exception flags |
| wb_ctl_ok | input | 1 | Control writeback valid |
| wb_ctl | input | 13 | Control writeback data |
| mts_en | input | 1 | Whole-word write strobe |
| mts_word | input | 32 | Whole-word write data |
| rd_vol | output | 7 | Stored volatile part |
| rd_stk | output | 12 | Stored sticky part |
| rd_ctl | output | 13 | Control part including fixed bits |
| rd_word | output | 32 | Concatenated status word |
| sticky_changed | output | 1 | One-cycle pulse after a merge that set a new flag |

## Verification
The sticky path is driven with flags that are new, flags that are already set, a zero value with ok high, and nonzero data with ok low. These cases separate a true OR-merge from an overwrite and a suppressed write from one that fires. The ok bits are toggled one at a time while the other pairs carry data, so crossed enables are exposed. Whole-word writes are issued together with conflicting writebacks to show the priority and the clearing of the sticky flags. All-ones control writes show which control bits are hard-wired. A long run of mixed random records is then compared against the reference model on every clock.

// File: rtl/fpsr_split_regs.sv
module fpsr_split_regs #(
  parameter int VOL_W = 7,
  parameter int STK_W = 12,
  parameter int CTL_W = 13,
  parameter logic [CTL_W-1:0] CTL_LIVE  = 13'h00FF,
  parameter logic [CTL_W-1:0] CTL_FIXED = 13'h0000,
  parameter logic [CTL_W-1:0] CTL_RESET = 13'h0000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wb_vol_ok,
  input  logic [VOL_W-1:0]             wb_vol,
  input  logic                         wb_stk_ok,
  input  logic [STK_W-1:0]             wb_stk,
  input  logic                         wb_ctl_ok,
  input  logic [CTL_W-1:0]             wb_ctl,
  input  logic                         mts_en,
  input  logic [VOL_W+STK_W+CTL_W-1:0] mts_word,
  output logic [VOL_W-1:0]             rd_vol,
  output logic [STK_W-1:0]             rd_stk,
  output logic [CTL_W-1:0]             rd_ctl,
  output logic [VOL_W+STK_W+CTL_W-1:0] rd_word,
  output logic                         sticky_changed
);
  localparam int STK_LO = VOL_W;
  localparam int CTL_LO = VOL_W + STK_W;
  localparam int WORD_W = VOL_W + STK_W + CTL_W;

  logic [VOL_W-1:0] vol_q;
  logic [STK_W-1:0] stk_q;
  logic             chg_q;

  wire [VOL_W-1:0] mts_vol = mts_word[STK_LO-1:0];
  wire [STK_W-1:0] mts_stk = mts_word[CTL_LO-1:STK_LO];
  wire [CTL_W-1:0] mts_ctl = mts_word[WORD_W-1:CTL_LO];

  wire [STK_W-1:0] stk_fresh = wb_stk & ~stk_q;
  wire             stk_merge = !mts_en && wb_stk_ok && (|stk_fresh);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vol_q <= '0;
      stk_q <= '0;
      chg_q <= 1'b0;
    end else begin
      chg_q <= stk_merge;
      if (mts_en) begin
        vol_q <= mts_vol;
        stk_q <= mts_stk;
      end else begin
        if (wb_vol_ok) vol_q <= wb_vol;
        if (stk_merge) stk_q <= stk_q | wb_stk;
      end
    end
  end

  for (genvar b = 0; b < CTL_W; b++) begin : g_ctl
    if (CTL_LIVE[b]) begin : g_live
      logic bit_q;
      always_ff @(posedge clk) begin
        if (!rst_n)         bit_q <= CTL_RESET[b];
        else if (mts_en)    bit_q <= mts_ctl[b];
        else if (wb_ctl_ok) bit_q <= wb_ctl[b];
      end
      assign rd_ctl[b] = bit_q;
    end else begin : g_fixed
      assign rd_ctl[b] = CTL_FIXED[b];
    end
  end

  assign rd_vol         = vol_q;
  assign rd_stk         = stk_q;
  assign rd_word        = {rd_ctl, stk_q, vol_q};
  assign sticky_changed = chg_q;

  assert_vol_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mts_en && !wb_vol_ok) |=> $stable(rd_vol));

  assert_stk_monotone_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mts_en |=> ((rd_stk & $past(rd_stk)) == $past(rd_stk)));

  assert_chg_means_new_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_changed |-> (rd_stk != $past(rd_stk)));

  assert_stk_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mts_en && !wb_stk_ok) |=> (!sticky_changed && $stable(rd_stk)));

  assert_ctl_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mts_en && !wb_ctl_ok) |=> $stable(rd_ctl));

  assert_mts_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mts_en |=> (!sticky_changed && rd_stk == $past(mts_word[CTL_LO-1:STK_LO])
               && rd_vol == $past(mts_word[STK_LO-1:0])));
endmodule

// File: tb/test_fpsr_split_regs.sv
`timescale 1ns/1ps
module test_fpsr_split_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wb_vol_ok = 0, wb_stk_ok = 0, wb_ctl_ok = 0, mts_en = 0;
  logic [6:0]  wb_vol = '0;
  logic [11:0] wb_stk = '0;
  logic [12:0] wb_ctl = '0;
  logic [31:0] mts_word = '0;
  logic [6:0]  rd_vol;
  logic [11:0] rd_stk;
  logic [12:0] rd_ctl;
  logic [31:0] rd_word;
  logic        sticky_changed;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [6:0]  m_vol = '0;
  logic [11:0] m_stk = '0;
  logic [12:0] m_ctl = '0;
  logic        m_chg = 1'b0;
  localparam logic [12:0] LIVE = 13'h00FF;

  always #10 clk = ~clk;

  fpsr_split_regs i_fpsr_split_regs (
    .clk(clk), .rst_n(rst_n),
    .wb_vol_ok(wb_vol_ok), .wb_vol(wb_vol),
    .wb_stk_ok(wb_stk_ok), .wb_stk(wb_stk),
    .wb_ctl_ok(wb_ctl_ok), .wb_ctl(wb_ctl),
    .mts_en(mts_en), .mts_word(mts_word),
    .rd_vol(rd_vol), .rd_stk(rd_stk), .rd_ctl(rd_ctl),
    .rd_word(rd_word), .sticky_changed(sticky_changed)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk({tag, " word"}, 64'(rd_word), 64'({m_ctl, m_stk, m_vol}));
    chk({tag, " chg"}, 64'(sticky_changed), 64'(m_chg));
    chk("R2 vol slice", 64'(rd_word[6:0]), 64'(rd_vol));
    chk("R2 stk slice", 64'(rd_word[18:7]), 64'(rd_stk));
    chk("R2 ctl slice", 64'(rd_word[31:19]), 64'(rd_ctl));
  endtask

  task automatic step(input string tag,
                      input logic vo, input logic [6:0] v,
                      input logic so, input logic [11:0] s,
                      input logic co, input logic [12:0] c,
                      input logic me, input logic [31:0] w);
    wb_vol_ok = vo; wb_vol = v; wb_stk_ok = so; wb_stk = s;
    wb_ctl_ok = co; wb_ctl = c; mts_en = me; mts_word = w;
    if (me) begin
      m_vol = w[6:0]; m_stk = w[18:7]; m_ctl = w[31:19] & LIVE; m_chg = 0;
    end else begin
      m_chg = so && ((s & ~m_stk) != 0);
      if (vo) m_vol = v;
      if (so) m_stk = m_stk | s;
      if (co) m_ctl = c & LIVE;
    end
    @(posedge clk); #5;
    compare_all(tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5;
    compare_all("R1 held reset");
    rst_n = 1'b1;
    step("R1 idle after reset", 0, '0, 0, '0, 0, '0, 0, '0);
    step("R3 vol write", 1, 7'h5A, 0, '0, 0, '0, 0, '0);
    step("R3 vol ignored", 0, 7'h11, 0, '0, 0, '0, 0, '0);
    step("R3 vol rewrite", 1, 7'h03, 0, '0, 0, '0, 0, '0);
    step("R4 R5 first flags", 0, '0, 1, 12'h005, 0, '0, 0, '0);
    step("R5 pulse ends", 0, '0, 0, '0, 0, '0, 0, '0);
    step("R5 already set", 0, '0, 1, 12'h004, 0, '0, 0, '0);
    step("R5 zero merge", 0, '0, 1, 12'h000, 0, '0, 0, '0);
    step("R4 stk ignored", 0, '0, 0, 12'hFFF, 0, '0, 0, '0);
    step("R4 partial new", 0, '0, 1, 12'h035, 0, '0, 0, '0);
    step("R5 back to back", 0, '0, 1, 12'h800, 0, '0, 0, '0);
    step("R6 ctl write", 0, '0, 0, '0, 1, 13'h0042, 0, '0);
    step("R6 ctl ignored", 0, '0, 0, '0, 0, 13'h1FFF, 0, '0);
    step("R8 fixed bits", 0, '0, 0, '0, 1, 13'h1FFF, 0, '0);
    step("R9 only vol", 1, 7'h7F, 0, 12'hFFF, 0, 13'h0000, 0, '0);
    step("R9 only ctl", 0, 7'h00, 0, 12'hFFF, 1, 13'h0013, 0, '0);
    step("R9 only stk", 0, 7'h00, 1, 12'h100, 0, 13'h1FFF, 0, '0);
    step("R7 mts clears sticky", 1, 7'h01, 1, 12'hFFF, 1, 13'h1FFF, 1, 32'h0000_0000);
    step("R7 mts full word", 0, '0, 0, '0, 0, '0, 1, 32'hFFFF_FFFF);
    step("R7 mts priority", 1, 7'h00, 1, 12'h000, 1, 13'h0000, 1, 32'h1234_5678);
    step("R5 after mts", 0, '0, 1, 12'h001, 0, '0, 0, '0);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r = $urandom;
      logic [31:0] r2 = $urandom;
      step("R4 R9 random", r[0], r2[6:0], r[1], r2[18:7] & 12'($urandom), r[2], r2[31:19],
           (r[7:3] == 5'd0), $urandom);
    end
    rst_n = 1'b0;
    m_vol = '0; m_stk = '0; m_ctl = '0; m_chg = 0;
    wb_vol_ok = 0; wb_stk_ok = 0; wb_ctl_ok = 0; mts_en = 0;
    @(posedge clk); #5;
    compare_all("R1 reset again");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule